// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Single-Level Table Walk

This block turns a logical address from a processor into a physical address for a paged memory system. The logical address is cut into a page index in its upper bits and an in-page offset in its lower bits. The physical address is the frame number for that page, placed above the same offset. The frame number comes from a small fully associative cache of recent translations. Each cached entry is tagged with the owner's process number, so translations for several processes can sit side by side.

If no entry matches both the page and the current process number, the block stops accepting requests. It then issues one read to an external page table, at the table base register plus the page index, and waits as long as the memory needs. It stores the returned frame in the cache and answers the request. Software-side inputs load the table base and the current process number. A separate input empties the whole cache at once.

Top module: `pid_tlb_xlate`

## Requirements
- R1: The physical address is {frame, offset}: the frame number sits above the unchanged OFF_W-bit offset. With the defaults, the page index is logical bits [15:13] and the offset is bits [12:0]. For example, logical 18325 on page 2, with frame 4'hB, gives 92053.
- R2: A request hits when a valid entry holds its page and the current process number. On a hit, rsp_valid is high for one cycle, in the cycle after acceptance, and no memory read is issued.
- R3: A miss issues exactly one memory read at address base + page, where the page is zero-extended and the sum wraps modulo 2^MA_W. req_ready stays low from the cycle after acceptance until the answer is delivered.
- R4: The frame returned on mem_rsp_frame forms the answer one cycle after mem_rsp_valid. It is also written into the cache, so that a repeat of the same page under the same process number hits.
- R5: A lookup only hits on an entry whose process tag equals the current process register. A tag mismatch is handled as a miss. Entries for the same page under different process numbers coexist and each returns its own frame.
- R6: A fill goes to the lowest-numbered invalid entry if there is one. Otherwise it goes to the entry named by a round-robin pointer. The pointer resets to 0 and steps by one, wrapping after the last entry, on every fill.
- R7: A one-cycle pulse on flush marks every entry invalid from the next cycle. A fill in the same cycle is dropped as well.
- R8: Writing the table base or the process register leaves the cached entries untouched.
- R9: After reset: all entries are invalid, the process number and the table base are 0, req_ready is high, and rsp_valid and mem_req_valid are low.
- R10: mem_req_valid stays high, with a stable mem_req_addr, until mem_req_ready is seen. The response may come any number of cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | PAGE_W+OFF_W | Logical address |
| rsp_valid | output | 1 | One-cycle pulse with the result |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MA_W | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_frame | input | FRAME_W | Frame number read from the table |
| base_we | input | 1 | Load the table base |
| base_wdata | input | MA_W | New table base |
| pid_we | input | 1 | Load the current process number |
| pid_wdata | input | PID_W | New process number |
| flush | input | 1 | Invalidate all entries |

## Verification
A corrupted tag, valid bit or victim pointer shows up at the ports in one of two ways. Either a read appears on the memory port where the bench's model expects a hit, or a hit appears where it expects a walk. Both are visible on the very request that touches the faulty entry. Eviction order is confirmed by a sequence of page requests that ends by re-requesting pages whose survival depends on the exact victim. A wrong frame or a wrong walk address gives a wrong physical address in the single response cycle.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 3,
  parameter int FRAME_W = 4,
  parameter int PID_W   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAGE_W-1:0]  look_page,
  input  logic [PID_W-1:0]   look_pid,
  output logic               hit,
  output logic [FRAME_W-1:0] hit_frame,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [PID_W-1:0]   fill_pid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               flush,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [PAGE_W-1:0]  page_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (flush)   valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        page_q[e]  <= '0;
        pid_q[e]   <= '0;
        frame_q[e] <= '0;
      end else if (fill_en && fill_idx == IDX_W'(e)) begin
        page_q[e]  <= fill_page;
        pid_q[e]   <= fill_pid;
        frame_q[e] <= fill_frame;
      end
    end
    assign hit_vec[e] = valid_q[e] && (page_q[e] == look_page) && (pid_q[e] == look_pid);
  end

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_frame = hit_frame | frame_q[i];
  end

  assign hit       = |hit_vec;
  assign valid_vec = valid_q;

  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  assign victim_idx = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       rr_q <= '0;
    else if (fill_en) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  p_rr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && rr_q != IDX_W'(ENTRIES - 1)) |=> (rr_q == $past(rr_q) + 1'b1));
  p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_vec)) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/pid_tlb_xlate.sv
module pid_tlb_xlate
  import xlt_pkg::*;
#(
  parameter int PAGE_W  = 3,
  parameter int OFF_W   = 13,
  parameter int FRAME_W = 4,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 4,
  parameter int MA_W    = 16,
  localparam int LA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_laddr,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [FRAME_W-1:0] mem_rsp_frame,
  input  logic               base_we,
  input  logic [MA_W-1:0]    base_wdata,
  input  logic               pid_we,
  input  logic [PID_W-1:0]   pid_wdata,
  input  logic               flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [PA_W-1:0] f_join(input logic [FRAME_W-1:0] fr,
                                             input logic [OFF_W-1:0] off);
    return {fr, off};
  endfunction

  function automatic logic [MA_W-1:0] f_walk_addr(input logic [MA_W-1:0] base,
                                                  input logic [PAGE_W-1:0] pg);
    return base + MA_W'(pg);
  endfunction

  walk_state_e        state_q;
  logic [MA_W-1:0]    base_q;
  logic [PID_W-1:0]   pid_q;
  logic [PAGE_W-1:0]  pend_page;
  logic [OFF_W-1:0]   pend_off;
  logic [PID_W-1:0]   pend_pid;
  logic [MA_W-1:0]    pend_addr;
  logic               rsp_valid_q;
  logic [PA_W-1:0]    rsp_paddr_q;

  logic [PAGE_W-1:0]  page_in;
  logic [OFF_W-1:0]   off_in;
  logic               lookup_hit;
  logic [FRAME_W-1:0] lookup_frame;
  logic               accept, hit_accept, miss_accept, walk_done;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;

  assign page_in     = req_laddr[LA_W-1:OFF_W];
  assign off_in      = req_laddr[OFF_W-1:0];
  assign req_ready   = (state_q == WK_IDLE);
  assign accept      = req_valid && req_ready;
  assign hit_accept  = accept && lookup_hit;
  assign miss_accept = accept && !lookup_hit;
  assign walk_done   = (state_q == WK_WAIT) && mem_rsp_valid;

  xlt_cam #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .PID_W(PID_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .look_page(page_in), .look_pid(pid_q),
    .hit(lookup_hit), .hit_frame(lookup_frame),
    .fill_en(walk_done), .fill_idx(victim_idx),
    .fill_page(pend_page), .fill_pid(pend_pid), .fill_frame(mem_rsp_frame),
    .flush(flush), .valid_vec(valid_vec)
  );

  xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_vec), .fill_en(walk_done), .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= WK_IDLE;
      base_q      <= '0;
      pid_q       <= '0;
      pend_page   <= '0;
      pend_off    <= '0;
      pend_pid    <= '0;
      pend_addr   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (base_we) base_q <= base_wdata;
      if (pid_we)  pid_q  <= pid_wdata;
      unique case (state_q)
        WK_IDLE: begin
          if (hit_accept) begin
            rsp_valid_q <= 1'b1;
            rsp_paddr_q <= f_join(lookup_frame, off_in);
          end else if (miss_accept) begin
            pend_page <= page_in;
            pend_off  <= off_in;
            pend_pid  <= pid_q;
            pend_addr <= f_walk_addr(base_q, page_in);
            state_q   <= WK_ISSUE;
          end
        end
        WK_ISSUE: if (mem_req_ready) state_q <= WK_WAIT;
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_paddr_q <= f_join(mem_rsp_frame, pend_off);
            state_q     <= WK_IDLE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == WK_ISSUE);
  assign mem_req_addr  = pend_addr;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_paddr     = rsp_paddr_q;

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_hit_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> (rsp_valid && !mem_req_valid));
  p_miss_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_accept |=> (!req_ready && mem_req_valid && !rsp_valid));
  p_walk_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> (rsp_valid && req_ready));
endmodule

// File: tb/test_pid_tlb_xlate.sv
module test_pid_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_laddr = '0;
  logic        rsp_valid;
  logic [16:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [3:0]  mem_rsp_frame = '0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        pid_we = 1'b0;
  logic [3:0]  pid_wdata = '0;
  logic        flush = 1'b0;

  always #10 clk = ~clk;

  pid_tlb_xlate i_pid_tlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frame(mem_rsp_frame),
    .base_we(base_we), .base_wdata(base_wdata), .pid_we(pid_we), .pid_wdata(pid_wdata),
    .flush(flush)
  );

  typedef struct {
    logic [16:0] paddr;
    bit          walk;
    logic [15:0] maddr;
    int          walks0;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [3:0]  ptmem [64];
  int          nchk = 0;
  int          nfail = 0;
  int          walks = 0;
  logic [15:0] last_maddr = '0;
  logic [16:0] last_rsp = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: variable ready stalls and response latency
  int   tick = 0;
  bit   pend = 1'b0;
  int   pend_cnt = 0;
  logic [3:0] pend_frame = '0;
  always @(negedge clk) begin
    tick++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_frame = pend_frame;
        pend = 1'b0;
      end else pend_cnt--;
    end
    mem_req_ready = (tick % 4 != 1) && (tick % 4 != 2);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1'b1;
      pend_cnt = tick % 3;
      pend_frame = ptmem[mem_req_addr[5:0]];
      last_maddr = mem_req_addr;
      walks++;
    end
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      last_rsp = rsp_paddr;
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected response", 32'(rsp_paddr), 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rsp_paddr == it.paddr, {it.tag, " paddr"}, 32'(rsp_paddr), 32'(it.paddr));
        check((walks - it.walks0) == (it.walk ? 1 : 0), {it.tag, " walk count"},
              32'(walks - it.walks0), it.walk ? 32'd1 : 32'd0);
        if (it.walk)
          check(last_maddr == it.maddr, {it.tag, " R3 walk addr"}, 32'(last_maddr), 32'(it.maddr));
      end
    end
  end

  task automatic xlate(input logic [15:0] la, input bit walk, input logic [15:0] maddr, input string tag);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.paddr  = {ptmem[maddr[5:0]], la[12:0]};
    it.walk   = walk;
    it.maddr  = maddr;
    it.walks0 = walks;
    it.tag    = tag;
    sb.push_back(it);
    req_valid = 1'b1;
    req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    if (walk) check(req_ready == 1'b0, {tag, " R3 ready low during walk"}, 32'(req_ready), 32'd0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic set_base(input logic [15:0] b);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic set_pid(input logic [3:0] p);
    @(negedge clk); pid_we = 1'b1; pid_wdata = p;
    @(negedge clk); pid_we = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ptmem[i] = 4'((i * 7 + 3) % 16);
    ptmem[6'h22] = 4'hB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R9 no response", 32'(rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R9 no memory read", 32'(mem_req_valid), 32'd0);

    set_base(16'h0020);
    xlate(16'd18325, 1'b1, 16'h0022, "R1 first walk");
    check(last_rsp == 17'd92053, "R1 worked example", 32'(last_rsp), 32'd92053);
    xlate(16'd18325, 1'b0, 16'h0022, "R2 repeat hit");
    xlate(16'h5FFF, 1'b0, 16'h0022, "R1 max offset");
    xlate(16'h4000, 1'b0, 16'h0022, "R1 zero offset");
    // fill remaining free entries (slots 1..3), pointer wraps to 0
    xlate(16'h0123, 1'b1, 16'h0020, "R4 page0 walk");
    xlate(16'h0123, 1'b0, 16'h0020, "R4 page0 hit");
    xlate(16'h2ABC, 1'b1, 16'h0021, "R10 page1 walk");
    xlate(16'h7000, 1'b1, 16'h0023, "R10 page3 walk");
    // full: round-robin eviction
    xlate(16'h8042, 1'b1, 16'h0024, "R6 page4 evicts slot0");
    xlate(16'h0001, 1'b0, 16'h0020, "R6 page0 kept");
    xlate(16'h4001, 1'b1, 16'h0022, "R6 page2 evicted");
    xlate(16'h0002, 1'b1, 16'h0020, "R6 page0 evicted");
    xlate(16'h6003, 1'b0, 16'h0023, "R6 page3 kept");
    xlate(16'h8004, 1'b0, 16'h0024, "R6 page4 kept");
    xlate(16'h2005, 1'b1, 16'h0021, "R6 page1 walk");
    xlate(16'h4006, 1'b0, 16'h0022, "R6 page2 kept");
    xlate(16'h6007, 1'b1, 16'h0023, "R6 page3 evicted");
    // flush
    do_flush();
    xlate(16'h4008, 1'b1, 16'h0022, "R7 walk after flush");
    // process tags and register writes without flush
    set_base(16'h0030);
    set_pid(4'd5);
    xlate(16'h4009, 1'b1, 16'h0032, "R5 other pid misses");
    set_pid(4'd0);
    xlate(16'h400A, 1'b0, 16'h0022, "R8 entry survives writes");
    set_pid(4'd5);
    xlate(16'h400B, 1'b0, 16'h0032, "R5 own frame per pid");
    // base wraparound
    do_flush();
    set_pid(4'd0);
    set_base(16'hFFFE);
    xlate(16'h600C, 1'b1, 16'h0001, "R3 base wraps");
    xlate(16'h600D, 1'b0, 16'h0001, "R4 hit after wrap");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule